// File: doc/BRIEF.md
# Mode-Configurable Video Line Delay

This block delays a stream of video samples by a programmable number of write-enabled clock cycles. It is built from two memory banks, each holding 4096 words of 12 bits. A 2-bit mode input groups the banks in one of three ways. In the first, the banks form two independent 12-bit delay lines, each with its own length. In the second, they carry three 8-bit lanes that share one length. In the third, they are chained into a single 12-bit line with up to twice the depth. The fourth mode code hands the banks over to a separate FIFO block. In that mode this block stays quiet and keeps its state.

Each bank takes its delay length from a shared 12-bit length bus. The length is captured while that bank's active-low load strobe is low. A programmed length N makes the output equal the input from N write-enabled cycles earlier. Loading a length restarts the line, and the output reads zero until the line has filled again. Both banks run on one clock. An asynchronous active-low reset is released synchronously inside the block.

Top module: `vlb_line_delay`

## Requirements
- R1: After reset, dout_a and dout_b are zero, and every bank length is 0.
- R2: In mode 2'b00, dout_a equals din_a from exactly N_A write-enabled cycles earlier, and dout_b equals din_b from N_B such cycles earlier. N_A is loaded by ld_a_n and N_B by ld_b_n, independently. Outputs update on the clock edge where wr_en is high.
- R3: A cycle with wr_en low does not advance either line, and both outputs hold their values.
- R4: After reset or after a length load, a bank's output is zero until N write-enabled cycles have passed.
- R5: A loaded length of 0 behaves as a delay of 1.
- R6: In mode 2'b01, three 8-bit lanes are carried. Lane 0 is din_a[11:4], lane 1 is {din_a[3:0], din_b[11:8]}, and lane 2 is din_b[7:0], with the same split on the outputs. One load through ld_a_n sets the length for both banks, and ld_b_n has no effect.
- R7: In mode 2'b10, dout_b equals din_a delayed by N_A + N_B write-enabled cycles, dout_a shows din_a delayed by N_A, and din_b is unused.
- R8: In mode 2'b11, both outputs are zero and wr_en advances neither line. On return to a line-buffer mode, each line resumes from the state it held before.
- R9: A length load clears that bank's output and restarts its fill. A load in the same cycle as wr_en wins, and that cycle's input sample is not stored.
- R10: The largest length, 4095, gives a delay of 4095 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both banks |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode | input | 2 | 00 dual, 01 three-lane, 10 double depth, 11 FIFO hand-off |
| wr_en | input | 1 | Sample enable, which advances the lines |
| len_in | input | 12 | Shared delay-length bus |
| ld_a_n | input | 1 | Active-low length load for bank A (both banks in mode 01) |
| ld_b_n | input | 1 | Active-low length load for bank B |
| din_a | input | 12 | Sample input for bank A |
| din_b | input | 12 | Sample input for bank B |
| dout_a | output | 12 | Delayed output of bank A |
| dout_b | output | 12 | Delayed output of bank B (chained line output in mode 10) |

## Verification
A length load and a sample write can fall in the same clock cycle. Both claim the bank's pointer. The bench raises ld_a_n low and wr_en high on the same edge, with a marked sample on din_a. It then counts enables from the next cycle. A correct design emits the first counted sample after exactly N enables and never shows the marked one. Any stored or pointer-shifted discard shows up as a wrong value at the fill boundary.

// File: rtl/vlb_pkg.sv
package vlb_pkg;
  typedef enum logic [1:0] {
    VLB_DUAL = 2'b00,
    VLB_TRI  = 2'b01,
    VLB_DEEP = 2'b10,
    VLB_FIFO = 2'b11
  } vlb_mode_e;
endpackage

// File: rtl/vlb_rst_sync.sv
module vlb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_out_n = sync_q[STAGES-1];
endmodule

// File: rtl/vlb_bank.sv
module vlb_bank #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              ld,
  input  logic [ADDR_W-1:0] len_in,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_nxt
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] len_q, len_n, wp_q, wp_n, lim;
  logic              full_q, full_n, wrap;
  logic [DATA_W-1:0] dout_q, dout_n, rd;

  assign lim  = (len_q == '0) ? '0 : len_q - 1'b1;
  assign wrap = (wp_q == lim);
  assign rd   = full_q ? mem[wp_q] : '0;

  always_comb begin
    len_n  = len_q;
    wp_n   = wp_q;
    full_n = full_q;
    dout_n = dout_q;
    if (ld) begin
      len_n  = len_in;
      wp_n   = '0;
      full_n = 1'b0;
      dout_n = '0;
    end else if (en) begin
      wp_n   = wrap ? '0 : wp_q + 1'b1;
      full_n = full_q | wrap;
      dout_n = rd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q  <= '0;
      wp_q   <= '0;
      full_q <= 1'b0;
      dout_q <= '0;
    end else if (ld || en) begin
      len_q  <= len_n;
      wp_q   <= wp_n;
      full_q <= full_n;
      dout_q <= dout_n;
    end
  end

  always_ff @(posedge clk) begin
    if (en && !ld) mem[wp_q] <= din;
  end

  assign dout     = dout_q;
  assign dout_nxt = rd;

  p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wp_q <= lim);
  p_fill_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !full_q |-> dout_q == '0);
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> ($stable(dout_q) && $stable(wp_q)));
  p_load_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (wp_q == '0 && !full_q && dout_q == '0));
endmodule

// File: rtl/vlb_line_delay.sv
module vlb_line_delay
  import vlb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] len_in,
  input  logic              ld_a_n,
  input  logic              ld_b_n,
  input  logic [DATA_W-1:0] din_a,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] dout_a,
  output logic [DATA_W-1:0] dout_b
);
  vlb_mode_e         mode_e;
  logic              rst_s_n;
  logic              en_a, en_b, ld_a, ld_b, quiet;
  logic [DATA_W-1:0] b_din, a_q, a_nxt, b_q, b_nxt;

  assign mode_e = vlb_mode_e'(mode);
  assign quiet  = (mode_e == VLB_FIFO);
  assign en_a   = wr_en && !quiet;
  assign en_b   = wr_en && !quiet;
  assign ld_a   = !ld_a_n;
  assign ld_b   = (mode_e == VLB_TRI) ? !ld_a_n : !ld_b_n;
  assign b_din  = (mode_e == VLB_DEEP) ? a_nxt : din_b;

  vlb_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_in_n(rst_n), .rst_out_n(rst_s_n)
  );

  vlb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank_a (
    .clk(clk), .rst_n(rst_s_n), .en(en_a), .ld(ld_a), .len_in(len_in),
    .din(din_a), .dout(a_q), .dout_nxt(a_nxt)
  );

  vlb_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank_b (
    .clk(clk), .rst_n(rst_s_n), .en(en_b), .ld(ld_b), .len_in(len_in),
    .din(b_din), .dout(b_q), .dout_nxt(b_nxt)
  );

  assign dout_a = quiet ? '0 : a_q;
  assign dout_b = quiet ? '0 : b_q;

  p_deep_feed_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mode_e == VLB_DEEP && en_a && !ld_a && !ld_b) |=> (b_q == $past(b_nxt)));
endmodule

// File: tb/vlb_line_delay_tb.sv
module vlb_line_delay_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  mode;
  logic        wr_en, ld_a_n, ld_b_n;
  logic [11:0] len_in, din_a, din_b, dout_a, dout_b;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vlb_line_delay u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .len_in(len_in),
    .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .din_a(din_a), .din_b(din_b),
    .dout_a(dout_a), .dout_b(dout_b)
  );

  function automatic logic [11:0] pat(int s, int i);
    return 12'((i * 37 + s * 101 + 5) & 12'hfff);
  endfunction

  function automatic logic [11:0] dly(int s, int k, int n);
    return (k > n) ? pat(s, k - n) : 12'h000;
  endfunction

  task automatic check(string req, logic [11:0] act, logic [11:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic la, logic lb, logic [11:0] len,
                     logic [11:0] a, logic [11:0] b);
    @(negedge clk);
    wr_en = we; ld_a_n = !la; ld_b_n = !lb; len_in = len; din_a = a; din_b = b;
    @(posedge clk);
    #2;
    wr_en = 1'b0; ld_a_n = 1'b1; ld_b_n = 1'b1;
  endtask

  task automatic t_reset();
    check("R1 dout_a", dout_a, 12'h000);
    check("R1 dout_b", dout_b, 12'h000);
    cyc(1, 0, 0, 0, 12'h123, 12'h456);
    check("R1 len0 a", dout_a, 12'h000);
    cyc(1, 0, 0, 0, 12'h777, 12'h888);
    check("R1 len0 a", dout_a, 12'h123);
    check("R1 len0 b", dout_b, 12'h456);
  endtask

  task automatic t_dual();
    int k = 0;
    mode = 2'b00;
    cyc(0, 1, 0, 12'd5, 0, 0);
    cyc(0, 0, 1, 12'd9, 0, 0);
    for (int i = 1; i <= 40; i++) begin
      logic we = (i % 7 != 3);
      if (we) k++;
      cyc(we, 0, 0, 0, pat(1, k), pat(2, k));
      check(we ? (k <= 5 ? "R4 a" : "R2 a") : "R3 a", dout_a, dly(1, k, 5));
      check(we ? (k <= 9 ? "R4 b" : "R2 b") : "R3 b", dout_b, dly(2, k, 9));
    end
  endtask

  task automatic t_len0();
    mode = 2'b00;
    cyc(0, 1, 0, 12'd0, 0, 0);
    for (int k = 1; k <= 4; k++) begin
      cyc(1, 0, 0, 0, pat(3, k), 12'h0);
      check("R5 a", dout_a, dly(3, k, 1));
    end
  endtask

  task automatic t_tri();
    mode = 2'b01;
    cyc(0, 1, 0, 12'd7, 0, 0);
    cyc(0, 0, 1, 12'd2, 0, 0);
    for (int k = 1; k <= 15; k++) begin
      logic [7:0] l0 = pat(4, k)[7:0];
      logic [7:0] l1 = pat(5, k)[7:0];
      logic [7:0] l2 = pat(6, k)[7:0];
      cyc(1, 0, 0, 0, {l0, l1[7:4]}, {l1[3:0], l2});
      check("R6 lane0", {4'h0, dout_a[11:4]}, {4'h0, dly(4, k, 7)[7:0]});
      check("R6 lane1", {4'h0, dout_a[3:0], dout_b[11:8]}, {4'h0, dly(5, k, 7)[7:0]});
      check("R6 lane2", {4'h0, dout_b[7:0]}, {4'h0, dly(6, k, 7)[7:0]});
    end
  endtask

  task automatic t_deep();
    mode = 2'b10;
    cyc(0, 1, 0, 12'd4, 0, 0);
    cyc(0, 0, 1, 12'd6, 0, 0);
    for (int k = 1; k <= 22; k++) begin
      cyc(1, 0, 0, 0, pat(7, k), 12'habc);
      check("R7 tap", dout_a, dly(7, k, 4));
      check("R7 out", dout_b, dly(7, k, 10));
    end
  endtask

  task automatic t_fifo();
    mode = 2'b00;
    cyc(0, 1, 0, 12'd3, 0, 0);
    for (int k = 1; k <= 5; k++) cyc(1, 0, 0, 0, pat(8, k), 12'h0);
    check("R2 pre", dout_a, dly(8, 5, 3));
    mode = 2'b11;
    for (int i = 0; i < 3; i++) begin
      cyc(1, 0, 0, 0, 12'hfff, 12'hfff);
      check("R8 a", dout_a, 12'h000);
      check("R8 b", dout_b, 12'h000);
    end
    mode = 2'b00;
    #1;
    check("R8 resume", dout_a, dly(8, 5, 3));
    cyc(1, 0, 0, 0, pat(8, 6), 12'h0);
    check("R8 next", dout_a, dly(8, 6, 3));
  endtask

  task automatic t_ldwr();
    mode = 2'b00;
    cyc(1, 1, 0, 12'd3, 12'h5a5, 12'h0);
    check("R9 clear", dout_a, 12'h000);
    for (int k = 1; k <= 6; k++) begin
      cyc(1, 0, 0, 0, pat(9, k), 12'h0);
      check("R9 a", dout_a, dly(9, k, 3));
    end
  endtask

  task automatic t_max();
    mode = 2'b00;
    cyc(0, 1, 0, 12'd4095, 0, 0);
    for (int k = 1; k <= 4100; k++) begin
      cyc(1, 0, 0, 0, pat(10, k), 12'h0);
      if (k == 4095 || k == 4096 || k == 4100)
        check("R10 a", dout_a, dly(10, k, 4095));
    end
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; wr_en = 1'b0; ld_a_n = 1'b1; ld_b_n = 1'b1;
    len_in = '0; din_a = '0; din_b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    t_dual();
    t_len0();
    t_tri();
    t_deep();
    t_fifo();
    t_ldwr();
    t_max();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule